// File: doc/BRIEF.md
# PUF Response Quality Monitor

This block gathers the raw statistics used to grade a physically unclonable function. A response word of `RESP_W` bits is loaded into a working register. A reference word is captured through an arm-then-load sequence. Each accepted measure strobe produces two registered values from the working response one cycle later:

- its count of 1 bits, which software turns into uniformity;
- its Hamming distance to the reference, which software turns into intra-chip reliability.

Both values are also added into running sums over `MEAS_CNT` re-measurements.

Once `MEAS_CNT` measurements have been accepted, a done flag rises and the block freezes until reset. The reference may be re-captured in the middle of a run without clearing the sums. The per-measurement distance is exposed on its own output, so software can load a response from another die as the reference and read raw pairwise distances for cross-die comparisons. Percentages and averaging are left to software.

Top module: `puf_quality_mon`

## Requirements
- R1: After reset, every output is zero: `weightOut`, `distOut`, `weightSum`, `distSum`, `measCount`, `measValid`, `done` and `refValid`.
- R2: A `respLoad` while armed stores `respIn` as the reference, sets `refValid` and disarms. Asserting `refArm` arms the block. This load leaves the working response unchanged.
- R3: A `respLoad` while not armed replaces the working response with `respIn`.
- R4: An accepted `measure` at clock edge k sets `measValid` high for exactly the cycle after edge k. In that same cycle, `weightOut` equals the number of 1 bits in the working response.
- R5: After an accepted measure, `distOut` equals the number of bit positions where the working response and the reference differ. It ranges from 0 (identical) to `RESP_W` (complement).
- R6: `weightSum` and `distSum` add each accepted measurement's weight and distance. They are sized to hold `MEAS_CNT*RESP_W` without wrapping.
- R7: `measCount` rises by one per accepted measure and never exceeds `MEAS_CNT`.
- R8: `done` rises in the same cycle that `measCount` reaches `MEAS_CNT`. Later `measure` strobes leave `measCount`, the sums and the per-measurement outputs unchanged, and keep `measValid` low.
- R9: A `measure` before any reference has been captured is ignored: no output changes and `measValid` stays low.
- R10: Re-arming and loading a new reference changes later distances but leaves the accumulated sums and `measCount` intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| respIn | input | RESP_W | Response word to load |
| respLoad | input | 1 | Load strobe for respIn |
| refArm | input | 1 | Makes the next load the reference |
| measure | input | 1 | Measure the working response |
| weightOut | output | clog2(RESP_W+1) | Ones count of last measurement |
| distOut | output | clog2(RESP_W+1) | Distance to reference of last measurement |
| measValid | output | 1 | One-cycle pulse after an accepted measure |
| weightSum | output | clog2(MEAS_CNT*RESP_W+1) | Accumulated weight |
| distSum | output | clog2(MEAS_CNT*RESP_W+1) | Accumulated distance |
| measCount | output | clog2(MEAS_CNT+1) | Accepted measurements |
| done | output | 1 | Measurement budget reached |
| refValid | output | 1 | A reference has been captured |

## Verification
Random response words drawn from a fixed-seed `$urandom` stream exercise the counting across mixed bit positions. These words would expose a dropped or duplicated bit in either popcount.

Directed words cover the extremes:

- a response identical to the reference, which must give a distance of zero;
- its complement, which must give the full width;
- all-zero and all-one words, which isolate weight from distance.

Measures issued before a reference exists, and past the budget, show whether gating is correct. A mid-run reference swap separates the distance path from the accumulator state.

// File: rtl/puf_qm_pkg.sv
package puf_qm_pkg;

  typedef struct packed {
    logic loadRef;
    logic loadResp;
    logic doMeas;
  } qmStrobes_t;

endpackage

// File: rtl/puf_qm_ctrl.sv
module puf_qm_ctrl
  import puf_qm_pkg::*;
#(
  parameter int MEAS_CNT = 16,
  localparam int CNT_W = $clog2(MEAS_CNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             respLoad,
  input  logic             refArm,
  input  logic             measure,
  output qmStrobes_t       strobes,
  output logic [CNT_W-1:0] measCount,
  output logic             done,
  output logic             refValid
);

  logic armed;

  always_comb begin
    strobes.loadRef  = respLoad & armed;
    strobes.loadResp = respLoad & ~armed;
    strobes.doMeas   = measure & refValid & ~done;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      refValid  <= 1'b0;
      measCount <= '0;
      done      <= 1'b0;
    end else begin
      if (strobes.loadRef) begin
        armed    <= 1'b0;
        refValid <= 1'b1;
      end
      if (refArm) armed <= 1'b1;
      if (strobes.doMeas) begin
        measCount <= measCount + 1'b1;
        if (measCount == CNT_W'(MEAS_CNT - 1)) done <= 1'b1;
      end
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    measCount <= CNT_W'(MEAS_CNT));

  // R8
  done_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (measCount == CNT_W'(MEAS_CNT)));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(measCount));

  // R9
  no_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refValid |=> measCount == 0);

endmodule

// File: rtl/puf_qm_datapath.sv
module puf_qm_datapath
  import puf_qm_pkg::*;
#(
  parameter int RESP_W   = 32,
  parameter int MEAS_CNT = 16,
  localparam int CW    = $clog2(RESP_W + 1),
  localparam int SUM_W = $clog2(MEAS_CNT * RESP_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qmStrobes_t        strobes,
  input  logic [RESP_W-1:0] respIn,
  output logic [CW-1:0]     weightOut,
  output logic [CW-1:0]     distOut,
  output logic              measValid,
  output logic [SUM_W-1:0]  weightSum,
  output logic [SUM_W-1:0]  distSum
);

  logic [RESP_W-1:0] curResp;
  logic [RESP_W-1:0] refResp;
  logic [RESP_W-1:0] diffBits;
  logic [CW-1:0]     weightNow;
  logic [CW-1:0]     distNow;

  assign diffBits = curResp ^ refResp;

  always_comb begin
    weightNow = '0;
    distNow   = '0;
    for (int b = 0; b < RESP_W; b++) begin
      weightNow = weightNow + CW'(curResp[b]);
      distNow   = distNow + CW'(diffBits[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curResp   <= '0;
      refResp   <= '0;
      weightOut <= '0;
      distOut   <= '0;
      measValid <= 1'b0;
      weightSum <= '0;
      distSum   <= '0;
    end else begin
      measValid <= strobes.doMeas;
      if (strobes.loadResp) curResp <= respIn;
      if (strobes.loadRef)  refResp <= respIn;
      if (strobes.doMeas) begin
        weightOut <= weightNow;
        distOut   <= distNow;
        weightSum <= weightSum + SUM_W'(weightNow);
        distSum   <= distSum + SUM_W'(distNow);
      end
    end
  end

  // R5
  dist_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    distOut <= CW'(RESP_W));

  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !measValid |-> $stable(distSum) && $stable(weightSum));

  // R6
  sum_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    measValid |-> distSum == $past(distSum) + SUM_W'(distOut));

  // R4
  pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    measValid |-> weightOut <= CW'(RESP_W));

endmodule

// File: rtl/puf_quality_mon.sv
module puf_quality_mon
  import puf_qm_pkg::*;
#(
  parameter int RESP_W   = 32,
  parameter int MEAS_CNT = 16,
  localparam int CW    = $clog2(RESP_W + 1),
  localparam int SUM_W = $clog2(MEAS_CNT * RESP_W + 1),
  localparam int CNT_W = $clog2(MEAS_CNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RESP_W-1:0] respIn,
  input  logic              respLoad,
  input  logic              refArm,
  input  logic              measure,
  output logic [CW-1:0]     weightOut,
  output logic [CW-1:0]     distOut,
  output logic              measValid,
  output logic [SUM_W-1:0]  weightSum,
  output logic [SUM_W-1:0]  distSum,
  output logic [CNT_W-1:0]  measCount,
  output logic              done,
  output logic              refValid
);

  qmStrobes_t strobes;

  puf_qm_ctrl #(.MEAS_CNT(MEAS_CNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .respLoad(respLoad), .refArm(refArm),
    .measure(measure), .strobes(strobes), .measCount(measCount),
    .done(done), .refValid(refValid)
  );

  puf_qm_datapath #(.RESP_W(RESP_W), .MEAS_CNT(MEAS_CNT)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .respIn(respIn),
    .weightOut(weightOut), .distOut(distOut), .measValid(measValid),
    .weightSum(weightSum), .distSum(distSum)
  );

endmodule

// File: tb/puf_quality_mon_tb.sv
module puf_quality_mon_tb_top;
  localparam int RESP_W = 32;
  localparam int MEAS_CNT = 16;
  localparam int CW = $clog2(RESP_W + 1);
  localparam int SUM_W = $clog2(MEAS_CNT * RESP_W + 1);
  localparam int CNT_W = $clog2(MEAS_CNT + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [RESP_W-1:0] respIn = '0;
  logic respLoad = 1'b0, refArm = 1'b0, measure = 1'b0;
  logic [CW-1:0] weightOut, distOut;
  logic measValid, done, refValid;
  logic [SUM_W-1:0] weightSum, distSum;
  logic [CNT_W-1:0] measCount;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [RESP_W-1:0] mCur = '0, mRef = '0;
  int mWSum = 0, mDSum = 0, mCnt = 0, lastW = 0, lastD = 0;

  always #10 clk = ~clk;

  puf_quality_mon #(.RESP_W(RESP_W), .MEAS_CNT(MEAS_CNT)) dut_i (.*);

  function automatic int pop(input logic [RESP_W-1:0] v);
    int c = 0;
    for (int i = 0; i < RESP_W; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadWord(input logic [RESP_W-1:0] w, input bit asRef);
    @(negedge clk);
    refArm = asRef;
    @(negedge clk);
    refArm = 1'b0;
    respIn = w;
    respLoad = 1'b1;
    @(negedge clk);
    respLoad = 1'b0;
    if (asRef) mRef = w; else mCur = w;
  endtask

  task automatic measureOnce(input string req);
    bit accept = (mCnt < MEAS_CNT) && refValid;
    @(negedge clk);
    measure = 1'b1;
    @(negedge clk);
    measure = 1'b0;
    if (accept) begin
      lastW = pop(mCur);
      lastD = pop(mCur ^ mRef);
      mWSum += lastW;
      mDSum += lastD;
      mCnt++;
    end
    chk({req, " valid"}, int'(measValid), int'(accept));
    chk({req, " weight"}, int'(weightOut), lastW);
    chk({req, " dist"}, int'(distOut), lastD);
    chk({req, " wsum"}, int'(weightSum), mWSum);
    chk({req, " dsum"}, int'(distSum), mDSum);
    chk({req, " count"}, int'(measCount), mCnt);
    chk({req, " done"}, int'(done), int'(mCnt == MEAS_CNT));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 weight", int'(weightOut), 0);
    chk("R1 dist", int'(distOut), 0);
    chk("R1 sums", int'(weightSum) + int'(distSum), 0);
    chk("R1 count", int'(measCount), 0);
    chk("R1 flags", int'({measValid, done, refValid}), 0);
    // R9 measure before reference is ignored
    loadWord(32'hF0F0_1234, 1'b0);
    measureOnce("R9");
    chk("R9 refValid", int'(refValid), 0);
    // R2 reference capture leaves working response alone
    loadWord(32'h0000_FFFF, 1'b1);
    chk("R2 refValid", int'(refValid), 1);
    measureOnce("R2");
    // R5 identical response gives zero, complement gives full width
    loadWord(32'h0000_FFFF, 1'b0);
    measureOnce("R5 same");
    chk("R5 zero dist", int'(distOut), 0);
    loadWord(32'hFFFF_0000, 1'b0);
    measureOnce("R5 compl");
    chk("R5 full dist", int'(distOut), RESP_W);
    // R4 weight extremes
    loadWord('0, 1'b0);
    measureOnce("R4 zeros");
    loadWord('1, 1'b0);
    measureOnce("R4 ones");
    // R3 random responses
    for (int k = 0; k < 5; k++) begin
      loadWord($urandom, 1'b0);
      measureOnce("R3 R6 rand");
    end
    // R10 new reference mid-run keeps sums
    loadWord($urandom, 1'b1);
    chk("R10 count kept", int'(measCount), mCnt);
    chk("R10 dsum kept", int'(distSum), mDSum);
    while (mCnt < MEAS_CNT) begin
      loadWord($urandom, 1'b0);
      measureOnce("R10 R7 rand");
    end
    // R8 frozen after done
    loadWord($urandom, 1'b0);
    measureOnce("R8 ignored");
    measureOnce("R8 ignored again");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule